// File: doc/BRIEF.md
# Coherent 64-bit Timestamp Reader

This block hands a bus master a consistent 64-bit timestamp. The timestamp comes from a free-running counter that can only be sampled as two 32-bit halves. The counter advances every cycle, and it can also jump when it is reloaded. A naive two-access read can therefore pair an upper half from one moment with a lower half from another.

The reader avoids this with a fixed sequence:
- It samples the upper half first, then the lower half, then the upper half again.
- If the two upper samples agree, the pair is returned.
- If they differ, the newer upper sample becomes the reference and another lower/upper pair is taken.
- A bounded number of such attempts is made. When the bound is exhausted, the last pair is returned with a failure flag.

The counter is part of the block. It takes a 64-bit reload as two writes: the low half is staged first, and the high-half write commits both halves. A separate clear-request control toggles an internal clear signal on every write that carries the request bit. A clean clear therefore needs two such writes, which leaves the signal low again. The counter is zeroed only on the write that raises the signal.

Top module: `ts_coherent_reader`

## Requirements
- R1: Reset (synchronous, active-low `rst_n`) brings the outputs to the following state: `rd_valid`=0, `rd_fail`=0, `rd_data`=0. The counter is zero while reset is held and counts up from the first clock after release.
- R2: The counter gains one per clock. With no upper-half change during a read, a request sampled at a clock edge gives `rd_valid` four cycles later. `rd_data` equals the counter value two cycles after the sampling edge, and `rd_fail` is 0.
- R3: Each attempt samples in this order: upper, then lower, then upper again. On an upper mismatch, the second upper sample becomes the reference and a new lower/upper pair is taken, adding two cycles per retry. The returned value is never a mix of halves across an upper change.
- R4: At most MAX_TRIES (10) lower/upper attempts are made. If all of them mismatch, `rd_valid` rises 22 cycles after the request with `rd_fail`=1. In that case `rd_data` holds the last upper sample above the last lower sample.
- R5: `rd_fail` and `rd_data` hold until the next completed read. A read that completes with matching halves clears `rd_fail`.
- R6: A `wr_lo` write only stages `wr_data` and leaves the counter untouched. A `wr_hi` write loads the counter with {`wr_data`, staged low} on that clock edge.
- R7: A `wr_ctl` write with `ctl_clr`=1 toggles the internal clear signal. The counter is zeroed on the write that raises it, and the write that lowers it has no effect on the count. A `wr_ctl` write with `ctl_clr`=0 has no effect.
- R8: When a clear rise and a `wr_hi` load happen on the same edge, the clear wins. A load, in turn, wins over the increment.
- R9: `rd_valid` is a one-cycle pulse. A request that arrives while a read is in progress is held, and it is served once the sequencer has gone back to idle. It then completes five cycles after the first result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_req | input | 1 | Request one coherent 64-bit read |
| wr_lo | input | 1 | Stage `wr_data` as the low half of a reload |
| wr_hi | input | 1 | Load counter with {`wr_data`, staged low half} |
| wr_data | input | HALF_W (32) | Write data for the reload halves |
| wr_ctl | input | 1 | Control-word write strobe |
| ctl_clr | input | 1 | Clear-request bit of the control word (toggles internal clear) |
| rd_data | output | 2*HALF_W (64) | Last returned timestamp |
| rd_valid | output | 1 | One-cycle pulse when `rd_data` is updated |
| rd_fail | output | 1 | Last read hit the retry bound |

## Verification
Two pairs of functions can land on the same clock edge.

The first pair is a reload and a clear. The bench stages a low half, then issues a high-half write and a raising clear-request write in the same cycle. A read then follows, and it must show the counter counting from zero rather than from the loaded value.

The second pair is a reload and an upper-half sample. The bench reloads the high half on every cycle while a read is in flight. Each upper sample then differs from its reference, which drives the sequencer to its retry bound. The bench judges the result by latency, by the failure flag, and by the exact last pair returned.

// File: rtl/ts_pkg.sv
// Package: shared types for the coherent timestamp reader.
// Assumes: nothing beyond IEEE 1800-2017.
package ts_pkg;

    // Read sequencer states, in the order the sequence visits them.
    typedef enum logic [2:0] {
        RS_IDLE = 3'd0,
        RS_HI0  = 3'd1,
        RS_LO   = 3'd2,
        RS_HI1  = 3'd3,
        RS_DONE = 3'd4
    } rd_state_t;

endpackage

// File: rtl/ts_counter.sv
// Module: ts_counter
// A 2*HALF_W free-running counter exposed as two halves. A reload is done by
// staging the low half and then writing the high half, which commits both.
// A clear-request write toggles an internal clear signal; the count is
// zeroed only on the write that raises it. Priority: clear > load > count.
// Assumes: strobes are single-cycle and synchronous to clk.
module ts_counter #(
    parameter int HALF_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lo_we,
    input  logic              hi_we,
    input  logic [HALF_W-1:0] wdata,
    input  logic              clr_we,
    input  logic              clr_bit,
    output logic [HALF_W-1:0] cnt_hi,
    output logic [HALF_W-1:0] cnt_lo
);
    localparam int CNT_W = 2 * HALF_W;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0]  cnt_q;
    logic [HALF_W-1:0] lo_stage_q;
    logic              tgl_q;
    logic              clr_rise;

    // Clear fires only on a request write that takes the toggle from low to high.
    assign clr_rise = clr_we & clr_bit & ~tgl_q;

    // Purpose: flip the internal clear signal on each request write.
    always_ff @(posedge clk) begin
        if (!rst_n)                tgl_q <= 1'b0;
        else if (clr_we && clr_bit) tgl_q <= ~tgl_q;
    end

    // Purpose: hold the low half of a pending reload.
    always_ff @(posedge clk) begin
        if (!rst_n)     lo_stage_q <= '0;
        else if (lo_we) lo_stage_q <= wdata;
    end

    // Purpose: the timestamp itself, with clear > load > increment.
    always_ff @(posedge clk) begin
        if (!rst_n)        cnt_q <= '0;
        else if (clr_rise) cnt_q <= '0;
        else if (hi_we)    cnt_q <= {wdata, lo_stage_q};
        else               cnt_q <= cnt_q + CNT_ONE;
    end

    assign cnt_hi = cnt_q[CNT_W-1:HALF_W];
    assign cnt_lo = cnt_q[HALF_W-1:0];

    // R7: a rising clear signal is accompanied by a zero count.
    a_r7_clear_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tgl_q) |-> (cnt_q == '0));

    // R8: a clear rise beats a simultaneous high-half load.
    a_r8_clear_beats_load: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_we && clr_rise) |=> (cnt_q == '0));

    // R6: a high-half write commits the staged low half with it.
    a_r6_load_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_we && !clr_rise) |=> (cnt_q == {$past(wdata), $past(lo_stage_q)}));

    // R2: with nothing else happening the count advances by one.
    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!hi_we && !clr_rise) |=> (cnt_q == $past(cnt_q) + CNT_ONE));

endmodule

// File: rtl/ts_read_seq.sv
// Module: ts_read_seq
// Sequencer that builds a coherent 2*HALF_W value from two halves sampled one
// per cycle: upper, lower, upper again; on an upper mismatch it retries the
// lower/upper pair with the new upper as reference, up to MAX_TRIES attempts.
// Assumes: the halves are live counter outputs; requests during a read are held.
module ts_read_seq
    import ts_pkg::*;
#(
    parameter int HALF_W    = 32,
    parameter int MAX_TRIES = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req,
    input  logic [HALF_W-1:0]   cnt_hi,
    input  logic [HALF_W-1:0]   cnt_lo,
    output logic [2*HALF_W-1:0] rd_data,
    output logic                rd_valid,
    output logic                rd_fail
);
    localparam int TRY_W = $clog2(MAX_TRIES + 1);
    localparam logic [TRY_W-1:0] TRY_MAX = TRY_W'(MAX_TRIES);
    localparam logic [TRY_W-1:0] TRY_ONE = TRY_W'(1);

    rd_state_t           state_q, state_d;
    logic [HALF_W-1:0]   hi_ref_q;
    logic [HALF_W-1:0]   lo_q;
    logic [TRY_W-1:0]    try_q;
    logic                pend_q;
    logic [2*HALF_W-1:0] data_q;
    logic                fail_q;
    logic                hi_match;
    logic                at_limit;

    assign hi_match = (cnt_hi == hi_ref_q);
    assign at_limit = (try_q == TRY_MAX);

    // Purpose: next-state selection for the sampling sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_IDLE: if (req || pend_q) state_d = RS_HI0;
            RS_HI0:  state_d = RS_LO;
            RS_LO:   state_d = RS_HI1;
            RS_HI1:  state_d = (hi_match || at_limit) ? RS_DONE : RS_LO;
            RS_DONE: state_d = RS_IDLE;
            default: state_d = RS_IDLE;
        endcase
    end

    // Purpose: state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RS_IDLE;
        else        state_q <= state_d;
    end

    // Purpose: remember a request that arrives while a read is in progress.
    always_ff @(posedge clk) begin
        if (!rst_n)                  pend_q <= 1'b0;
        else if (state_q == RS_IDLE) pend_q <= 1'b0;
        else if (req)                pend_q <= 1'b1;
    end

    // Purpose: capture the halves and count attempts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_ref_q <= '0;
            lo_q     <= '0;
            try_q    <= '0;
        end else begin
            unique case (state_q)
                RS_HI0: begin
                    hi_ref_q <= cnt_hi;
                    try_q    <= TRY_ONE;
                end
                RS_LO:  lo_q <= cnt_lo;
                RS_HI1: if (!hi_match && !at_limit) begin
                    hi_ref_q <= cnt_hi;
                    try_q    <= try_q + TRY_ONE;
                end
                default: ;
            endcase
        end
    end

    // Purpose: register the result and the failure flag on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
            fail_q <= 1'b0;
        end else if (state_q == RS_HI1) begin
            if (hi_match) begin
                data_q <= {hi_ref_q, lo_q};
                fail_q <= 1'b0;
            end else if (at_limit) begin
                data_q <= {cnt_hi, lo_q};
                fail_q <= 1'b1;
            end
        end
    end

    assign rd_data  = data_q;
    assign rd_fail  = fail_q;
    assign rd_valid = (state_q == RS_DONE);

    // R3: upper sample is followed by the lower one.
    a_r3_hi0_then_lo: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_HI0) |=> (state_q == RS_LO));

    // R3: lower sample is followed by the check of the upper half.
    a_r3_lo_then_hi1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_LO) |=> (state_q == RS_HI1));

    // R4: the attempt count never passes its bound.
    a_r4_try_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (try_q <= TRY_MAX));

    // R4: the failure flag only rises together with a completion.
    a_r4_fail_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_q) |-> rd_valid);

    // R9: valid is a single-cycle pulse.
    a_r9_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R9: a request seen mid-read is remembered.
    a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (req && state_q != RS_IDLE) |=> pend_q);

endmodule

// File: rtl/ts_coherent_reader.sv
// Module: ts_coherent_reader (top)
// Combines the split-access timestamp counter with the coherent read
// sequencer. The sequencer sees only the counter halves, as a bus master would.
// Assumes: one clock domain, synchronous active-low reset.
module ts_coherent_reader #(
    parameter int HALF_W    = 32,
    parameter int MAX_TRIES = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rd_req,
    input  logic                wr_lo,
    input  logic                wr_hi,
    input  logic [HALF_W-1:0]   wr_data,
    input  logic                wr_ctl,
    input  logic                ctl_clr,
    output logic [2*HALF_W-1:0] rd_data,
    output logic                rd_valid,
    output logic                rd_fail
);
    logic [HALF_W-1:0] ts_hi;
    logic [HALF_W-1:0] ts_lo;

    ts_counter #(.HALF_W(HALF_W)) u_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .lo_we   (wr_lo),
        .hi_we   (wr_hi),
        .wdata   (wr_data),
        .clr_we  (wr_ctl),
        .clr_bit (ctl_clr),
        .cnt_hi  (ts_hi),
        .cnt_lo  (ts_lo)
    );

    ts_read_seq #(.HALF_W(HALF_W), .MAX_TRIES(MAX_TRIES)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .req      (rd_req),
        .cnt_hi   (ts_hi),
        .cnt_lo   (ts_lo),
        .rd_data  (rd_data),
        .rd_valid (rd_valid),
        .rd_fail  (rd_fail)
    );

endmodule

// File: tb/test_ts_coherent_reader.sv
`timescale 1ns/1ps
module test_ts_coherent_reader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_req = 1'b0, wr_lo = 1'b0, wr_hi = 1'b0, wr_ctl = 1'b0, ctl_clr = 1'b0;
    logic [31:0] wr_data = '0;
    logic [63:0] rd_data;
    logic        rd_valid, rd_fail;
    int          errors = 0;
    int          checks = 0;

    always #2.5 clk = ~clk;

    ts_coherent_reader i_ts_coherent_reader (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_lo(wr_lo), .wr_hi(wr_hi),
        .wr_data(wr_data), .wr_ctl(wr_ctl), .ctl_clr(ctl_clr),
        .rd_data(rd_data), .rd_valid(rd_valid), .rd_fail(rd_fail)
    );

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%016h expected=0x%016h", tag, act, exp);
        end
    endtask

    // One negedge with the given input pattern applied (all others low).
    task automatic drive(input logic req, input logic lo, input logic hi,
                         input logic ctl, input logic clr, input logic [31:0] d);
        @(negedge clk);
        rd_req = req; wr_lo = lo; wr_hi = hi; wr_ctl = ctl; ctl_clr = clr; wr_data = d;
    endtask

    // Wait for valid after a request; lat counts negedges after the request.
    task automatic wait_done(output int lat);
        lat = 0;
        while (1) begin
            @(negedge clk);
            lat++;
            rd_req = 0; wr_lo = 0; wr_hi = 0; wr_ctl = 0; ctl_clr = 0;
            if (rd_valid || lat >= 40) break;
        end
    endtask

    task automatic load64(input logic [63:0] v);
        drive(0, 1, 0, 0, 0, v[31:0]);
        drive(0, 0, 1, 0, 0, v[63:32]);
    endtask

    task automatic read_expect(input string tag, input logic [63:0] exp,
                               input int exp_lat, input logic exp_fail);
        int lat;
        drive(1, 0, 0, 0, 0, 32'h0);
        wait_done(lat);
        check({tag, " latency"}, 64'(lat), 64'(exp_lat));
        check({tag, " data"}, rd_data, exp);
        check({tag, " fail"}, {63'd0, rd_fail}, {63'd0, exp_fail});
    endtask

    // R1: reset state and counting from zero after release.
    task automatic t_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        check("R1 valid in reset", {63'd0, rd_valid}, 64'd0);
        check("R1 fail in reset", {63'd0, rd_fail}, 64'd0);
        check("R1 data in reset", rd_data, 64'd0);
        rst_n = 1;
        read_expect("R1 first read", 64'd3, 4, 1'b0);
    endtask

    // R2: plain read with stable upper half.
    task automatic t_plain();
        load64(64'h12345678_00000010);
        read_expect("R2 plain", 64'h12345678_00000012, 4, 1'b0);
    endtask

    // R3: lower half carries into upper during the read.
    task automatic t_carry();
        load64(64'h00000005_FFFFFFFE);
        read_expect("R3 carry retry", 64'h00000006_00000002, 6, 1'b0);
    endtask

    // R4: upper reloaded every cycle so no attempt matches.
    task automatic t_limit();
        int j;
        drive(0, 1, 0, 0, 0, 32'h50);
        drive(1, 0, 1, 0, 0, 32'hA0);
        j = 0;
        while (1) begin
            @(negedge clk);
            j++;
            rd_req = 0;
            if (rd_valid || j >= 40) begin
                wr_hi = 0;
                break;
            end
            wr_hi = 1; wr_data = 32'hA0 + 32'(j);
        end
        wr_hi = 0;
        check("R4 limit latency", 64'(j), 64'd22);
        check("R4 limit fail", {63'd0, rd_fail}, 64'd1);
        check("R4 limit last pair", rd_data, 64'h000000B4_00000050);
    endtask

    // R5: next good read clears the failure flag.
    task automatic t_recover();
        @(negedge clk);
        check("R5 fail held", {63'd0, rd_fail}, 64'd1);
        load64(64'h00000001_00000000);
        read_expect("R5 recover", 64'h00000001_00000002, 4, 1'b0);
    endtask

    // R6: low write alone is only staged; high write commits it.
    task automatic t_stage();
        load64(64'h00000002_00000100);
        drive(0, 1, 0, 0, 0, 32'h0000DEAD);
        read_expect("R6 low only", 64'h00000002_00000103, 4, 1'b0);
        drive(0, 0, 1, 0, 0, 32'h7);
        read_expect("R6 high commit", 64'h00000007_0000DEAF, 4, 1'b0);
    endtask

    // R7: toggle semantics of the clear request.
    task automatic t_toggle();
        drive(0, 0, 0, 1, 1, 32'h0);
        drive(0, 0, 0, 1, 1, 32'h0);
        read_expect("R7 double write", 64'd3, 4, 1'b0);
        load64(64'h00000003_00000000);
        drive(0, 0, 0, 1, 0, 32'h0);
        read_expect("R7 bit clear ignored", 64'h00000003_00000003, 4, 1'b0);
        drive(0, 0, 0, 1, 1, 32'h0);
        read_expect("R7 rise clears", 64'd2, 4, 1'b0);
        load64(64'h00000004_00000000);
        drive(0, 0, 0, 1, 1, 32'h0);
        read_expect("R7 fall no clear", 64'h00000004_00000003, 4, 1'b0);
    endtask

    // R8: clear rise and high load on the same edge.
    task automatic t_collide();
        drive(0, 1, 0, 0, 0, 32'h1234);
        drive(0, 0, 1, 1, 1, 32'h9);
        read_expect("R8 clear beats load", 64'd2, 4, 1'b0);
        drive(0, 0, 0, 1, 1, 32'h0);
    endtask

    // R9: request while busy is held and served after idle.
    task automatic t_pending();
        int lat;
        load64(64'h00000005_00000000);
        drive(1, 0, 0, 0, 0, 32'h0);
        drive(0, 0, 0, 0, 0, 32'h0);
        drive(1, 0, 0, 0, 0, 32'h0);
        drive(0, 0, 0, 0, 0, 32'h0);
        @(negedge clk);
        check("R9 first valid", {63'd0, rd_valid}, 64'd1);
        check("R9 first data", rd_data, 64'h00000005_00000002);
        @(negedge clk);
        check("R9 valid pulse", {63'd0, rd_valid}, 64'd0);
        wait_done(lat);
        check("R9 held latency", 64'(lat), 64'd4);
        check("R9 held data", rd_data, 64'h00000005_00000007);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        t_reset();
        t_plain();
        t_carry();
        t_limit();
        t_recover();
        t_stage();
        t_toggle();
        t_collide();
        t_pending();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule